// File: doc/BRIEF.md
# Configurable-Format Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line that runs in another clock domain. The raw line is brought in through a two-stage synchronizer. A falling edge arms the receiver. The start bit is re-checked half a bit period later, and each later bit is sampled once per bit period at its centre. The bit period is a whole number of clock cycles, given by the parameter `BIT_CYCLES`, which is the clock frequency divided by the baud rate.

The frame format is chosen at run time. The data field can be 5, 6, 7 or 8 bits, parity can be off, even or odd, and the frame can end with one or two stop bits. The format inputs are taken only when a start edge is detected, so a frame in progress keeps the format it started with. A good frame gives the byte with a one-cycle strobe and, in the same cycle, a flag that reports a parity mismatch. A frame with a low stop bit gives no byte. In its place it gives a separate one-cycle framing-error pulse.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `data_valid`, `parity_err` and `frame_err` are low and `data_out` is zero, and they stay so while the line stays high.
- R2: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. A good frame raises `data_valid` for exactly one cycle with the byte on `data_out`.
- R3: `cfg_width` selects the data width: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits of `data_out` above the selected width read zero.
- R4: `cfg_parity` 1 selects even parity, where data plus parity bit hold an even count of ones. On a mismatch the byte is still delivered, and `parity_err` is high in the same cycle as `data_valid`.
- R5: `cfg_parity` 2 selects odd parity, where data plus parity bit hold an odd count of ones. It is reported as in R4. Values 0 and 3 mean no parity bit.
- R6: A stop bit sampled low gives a one-cycle `frame_err` pulse and no `data_valid`. `parity_err` stays low on such a frame.
- R7: With `cfg_two_stop` = 1, both stop bits are checked. A low level in only the second one also gives the R6 behaviour.
- R8: A low pulse shorter than half a bit period is rejected. No output results from it, and the next frame is received correctly.
- R9: Format inputs changed in the middle of a frame do not affect that frame.
- R10: Frames sent back to back, each with one stop bit and no idle time between them, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Raw serial line, asynchronous, idles high |
| cfg_width | input | 2 | Data width select (R3) |
| cfg_parity | input | 2 | Parity mode select (R4, R5) |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| data_out | output | 8 | Received byte, zero-extended |
| data_valid | output | 1 | One-cycle strobe for a good frame |
| parity_err | output | 1 | Parity mismatch, valid with data_valid |
| frame_err | output | 1 | One-cycle pulse for a low stop bit |

## Verification
The parity check and byte delivery act in the same cycle. The bench sends frames with correct and with deliberately wrong parity bits, in both parity modes, and requires `parity_err` to appear together with the `data_valid` strobe and never alone. A second collision is a frame that has both a wrong parity bit and a low stop bit. There the bench requires that only the framing pulse appears, with no byte and no parity flag. A monitor counts every strobe and pulse per frame, so a strobe that is too wide or doubled is reported as well.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int BIT_CYCLES = 434
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic [1:0] cfg_width,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_two_stop,
  output logic [7:0] data_out,
  output logic       data_valid,
  output logic       parity_err,
  output logic       frame_err
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  logic          s1, s2;
  state_t        st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic [1:0]    wid_q, par_q;
  logic          two_q, stop2, bad_stop, par_bit;

  wire       tick   = (cnt == LAST);
  wire [2:0] nlast  = {1'b0, wid_q} + 3'd4;
  wire       par_on = (par_q == 2'b01) || (par_q == 2'b10);
  wire       perr   = par_on && (^shreg ^ par_bit ^ (par_q == 2'b10));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      shreg <= '0;
      wid_q <= 2'd3;
      par_q <= 2'd0;
      two_q <= 1'b0;
      stop2 <= 1'b0;
      bad_stop <= 1'b0;
      par_bit <= 1'b0;
      data_out <= '0;
      data_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err <= 1'b0;
      cnt <= tick ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!s2) begin
            st <= S_START;
            wid_q <= cfg_width;
            par_q <= cfg_parity;
            two_q <= cfg_two_stop;
          end
        end
        S_START: if (cnt == MID) begin
          cnt <= '0;
          idx <= '0;
          shreg <= '0;
          stop2 <= 1'b0;
          bad_stop <= 1'b0;
          st <= s2 ? S_IDLE : S_DATA;
        end
        S_DATA: if (tick) begin
          shreg[idx] <= s2;
          idx <= idx + 1'b1;
          if (idx == nlast) st <= par_on ? S_PAR : S_STOP;
        end
        S_PAR: if (tick) begin
          par_bit <= s2;
          st <= S_STOP;
        end
        S_STOP: if (tick) begin
          if (two_q && !stop2) begin
            stop2 <= 1'b1;
            bad_stop <= !s2;
          end else begin
            st <= S_IDLE;
            if (bad_stop || !s2) frame_err <= 1'b1;
            else begin
              data_out <= shreg;
              data_valid <= 1'b1;
              parity_err <= perr;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  assert_width_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && wid_q == 2'd0) |-> (data_out[7:5] == 3'b000));
  assert_perr_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> data_valid);
  assert_no_perr_without_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !par_on) |-> !parity_err);
  assert_ferr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !data_valid);
  assert_ferr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> !(data_valid || frame_err));
endmodule

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT = 16;

  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b1;
  logic [1:0] cfg_width = 2'd3, cfg_parity = 2'd0;
  logic cfg_two_stop = 1'b0;
  logic [7:0] data_out;
  logic data_valid, parity_err, frame_err;

  int checks = 0, fails = 0;
  int nv = 0, nf = 0;
  logic [7:0] got_data;
  logic got_perr;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_rx #(.BIT_CYCLES(BIT)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_width(cfg_width),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .data_out(data_out),
    .data_valid(data_valid), .parity_err(parity_err), .frame_err(frame_err));

  always @(negedge clk) if (rst_n) begin
    if (data_valid) begin nv++; got_data = data_out; got_perr = parity_err; end
    if (frame_err) nf++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b, input int len);
    line_in = b;
    repeat (len) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input int pmode,
                      input int nstops, input int bad_stop, input logic flip_par);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nbits; i++) p ^= d[i];
    if (pmode == 2) p = ~p;
    p ^= flip_par;
    bit_out(1'b0, BIT);
    for (int i = 0; i < nbits; i++) bit_out(d[i], BIT);
    if (pmode == 1 || pmode == 2) bit_out(p, BIT);
    for (int s = 1; s <= nstops; s++)
      if (s == bad_stop) begin bit_out(1'b0, BIT*3/4); bit_out(1'b1, BIT - BIT*3/4); end
      else bit_out(1'b1, BIT);
  endtask

  task automatic clear_mon;
    nv = 0; nf = 0; got_data = 'x; got_perr = 1'bx;
  endtask

  task automatic frame_ok(input string req, input logic [7:0] d, input int w,
                          input int pm, input int ns, input logic flip, input logic [7:0] exp);
    cfg_width = 2'(w - 5); cfg_parity = 2'(pm); cfg_two_stop = (ns == 2);
    clear_mon();
    send(d, w, pm, ns, 0, flip);
    repeat (2*BIT) @(negedge clk);
    check({req, " valid count"}, nv, 1);
    check({req, " frame_err count"}, nf, 0);
    check({req, " data"}, got_data, exp);
    check({req, " parity_err"}, got_perr, flip);
  endtask

  task automatic t_reset_R1;
    check("R1 data_out", data_out, 0);
    check("R1 strobes", {data_valid, parity_err, frame_err}, 0);
    clear_mon();
    repeat (5*BIT) @(negedge clk);
    check("R1 idle quiet", nv + nf, 0);
  endtask

  task automatic t_frame_err_R6;
    cfg_width = 2'd3; cfg_parity = 2'd1; cfg_two_stop = 1'b0;
    clear_mon();
    send(8'h5C, 8, 1, 1, 1, 1'b1);
    repeat (3*BIT) @(negedge clk);
    check("R6 frame_err count", nf, 1);
    check("R6 no valid", nv, 0);
  endtask

  task automatic t_second_stop_R7;
    cfg_width = 2'd2; cfg_parity = 2'd0; cfg_two_stop = 1'b1;
    clear_mon();
    send(8'h41, 7, 0, 2, 2, 1'b0);
    repeat (3*BIT) @(negedge clk);
    check("R7 frame_err count", nf, 1);
    check("R7 no valid", nv, 0);
  endtask

  task automatic t_glitch_R8;
    clear_mon();
    bit_out(1'b0, 3);
    bit_out(1'b1, 3*BIT);
    check("R8 glitch ignored", nv + nf, 0);
    frame_ok("R8 after glitch", 8'hC3, 8, 0, 1, 1'b0, 8'hC3);
  endtask

  task automatic t_cfg_mid_R9;
    cfg_width = 2'd3; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
    clear_mon();
    bit_out(1'b0, BIT);
    cfg_width = 2'd0; cfg_parity = 2'd2; cfg_two_stop = 1'b1;
    for (int i = 0; i < 8; i++) bit_out(8'hE7 >> i, BIT);
    bit_out(1'b1, 3*BIT);
    check("R9 valid count", nv, 1);
    check("R9 data kept 8 bits", got_data, 8'hE7);
    check("R9 no parity flag", got_perr, 1'b0);
  endtask

  task automatic t_back_to_back_R10;
    cfg_width = 2'd3; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
    clear_mon();
    send(8'h12, 8, 0, 1, 0, 1'b0);
    check("R10 first", got_data, 8'h12);
    send(8'h34, 8, 0, 1, 0, 1'b0);
    check("R10 second", got_data, 8'h34);
    send(8'hAB, 8, 0, 1, 0, 1'b0);
    repeat (2*BIT) @(negedge clk);
    check("R10 third", got_data, 8'hAB);
    check("R10 count", nv, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    frame_ok("R2 8N1", 8'hA5, 8, 0, 1, 1'b0, 8'hA5);
    frame_ok("R2 8N1 b", 8'h01, 8, 0, 1, 1'b0, 8'h01);
    frame_ok("R3 5 bits", 8'hFF, 5, 0, 1, 1'b0, 8'h1F);
    frame_ok("R3 6 bits", 8'h2A, 6, 0, 2, 1'b0, 8'h2A);
    frame_ok("R3 7 bits", 8'h55, 7, 3, 1, 1'b0, 8'h55);
    frame_ok("R4 even ok", 8'h96, 8, 1, 1, 1'b0, 8'h96);
    frame_ok("R4 even bad", 8'h97, 8, 1, 1, 1'b1, 8'h97);
    frame_ok("R5 odd ok", 8'h3C, 8, 2, 2, 1'b0, 8'h3C);
    frame_ok("R5 odd bad", 8'h15, 5, 2, 1, 1'b1, 8'h15);
    t_frame_err_R6();
    t_second_stop_R7();
    t_glitch_R8();
    t_cfg_mid_R9();
    t_back_to_back_R10();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule